// File: doc/BRIEF.md
# Programmable Timer Counter Channel

A single 16-bit timer channel. It counts either the system clock, divided by a power of two, or rising edges of an external pulse input. A second external input acts as a trigger. The channel has two compare registers, a load register and a counter register, and it drives an output flag pin and an interrupt line. Software programs it through a small synchronous register bus: a write takes effect at the clock edge that samples it, and read data is registered, so it appears one cycle after the read strobe.

Register addresses are: 0 control, 1 status, 2 counter, 3 load, 4 compare A, 5 compare B.

Control fields:
- [2:0] count mode: 000 stop, 001 edge count, 110 triggered one-shot.
- [5:3] output mode: 000 low, 011 toggle on compare, 111 gated clock.
- [8:6] prescale exponent n.
- [9] external primary source.
- [10] use compare B.
- [11] interrupt enable.

Status fields:
- [0] sticky compare flag.
- [1] counter running.
- [2] output flag level.

A count step always loads the next value from a match state that was latched when the counter reached the compare value. A rewrite of the compare register between count steps therefore cannot turn a reload into an increment. With the second compare register, software can prepare the next period while the current one runs.

Top module: `tmr_chan`

## Requirements
- R1: After reset, control, status, counter, load and both compare registers read 0, and `oflag_o` and `irq_o` are low.
- R2: In count mode 001 the counter advances by one on each rising edge of the primary source. With control bit 9 set, that source is `prim_i`, seen through a two-flop synchronizer.
- R3: On the count step that follows a compare match, the counter takes the load register value. This holds even when the compare register was rewritten after the match.
- R4: A compare event occurs when a count step makes the counter equal to the active compare value. It sets status bit 0. Writing 1 to status bit 0 clears the flag; writing 0 leaves it unchanged. `irq_o` equals that flag ANDed with control bit 11.
- R5: Control bit 10 selects compare B (address 5) as the active compare value in place of compare A (address 4).
- R6: In count mode 110 the counter holds its value until a rising edge on `sec_i`. The edge loads the counter from the load register and starts counting. Counting stops at the compare event. Status bit 1 reads 1 only while the counter is running.
- R7: A rising edge on `sec_i` while the one-shot is running has no effect on the counter.
- R8: In output mode 011, `oflag_o` inverts once per compare event.
- R9: In output mode 111, `oflag_o` shows one pulse per primary count step while the counter runs. It stays low while the counter does not run, for both internal and external sources.
- R10: With control bit 9 clear, the primary source makes one count step every 2^n system clocks, where n is control field [8:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid one cycle after the read strobe |
| prim_i | input | 1 | External primary count input |
| sec_i | input | 1 | Secondary trigger input |
| oflag_o | output | 1 | Output flag pin |
| irq_o | output | 1 | Compare interrupt |

## Verification
A corrupt latched match state shows up at the very next count step: the counter reads back one above the compare value instead of the load value. A one-shot that arms without a trigger, or fails to disarm, shows up within one primary pulse. The counter then moves while it should hold, and gated-clock pulses reach `oflag_o` before the trigger. The prescaler divide ratio is measured over a fixed window of forty clocks, so a wrong ratio changes the count read back by several units.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] CM_EDGE = 3'b001;
  localparam logic [2:0] CM_TRIG = 3'b110;
  localparam logic [2:0] OM_TOGGLE = 3'b011;
  localparam logic [2:0] OM_GATE = 3'b111;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_LOAD = 3'd3;
  localparam logic [2:0] A_CMPA = 3'd4;
  localparam logic [2:0] A_CMPB = 3'd5;

  typedef struct packed {
    logic       irq_en;
    logic       cmp_sel;
    logic       src_ext;
    logic [2:0] psc;
    logic [2:0] out_mode;
    logic [2:0] cnt_mode;
  } ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic sync_o,
  output logic dly_o
);
  logic s1_q, s2_q, s3_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end
  assign sync_o = s2_q;
  assign dly_o  = s3_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o,
  output logic             lvl_o
);
  localparam int PRE_W = 1 << PSC_W;

  logic [PRE_W-1:0] pre_q, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_W'(1);
  end

  assign mask   = (PRE_W'(1) << psc_i) - PRE_W'(1);
  assign tick_o = (pre_q & mask) == mask;
  assign lvl_o  = (psc_i == '0) ? 1'b1 : pre_q[psc_i - PSC_W'(1)];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic pend_q, act_q, start, step;

  assign run_o = (mode_i == CM_EDGE) || (mode_i == CM_TRIG && act_q);
  assign start = (mode_i == CM_TRIG) && trig_i && !act_q;
  assign step  = run_o && tick_i;
  // latched match decides the reload, not a fresh compare
  assign nxt   = pend_q ? load_i : cnt_q + CNT_W'(1);
  assign evt_o = step && !cnt_we_i && (nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (cnt_we_i) begin
      cnt_q  <= cnt_wdata_i;
      pend_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= load_i;
      pend_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= nxt;
      pend_q <= (nxt == cmp_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 act_q <= 1'b0;
    else if (mode_i != CM_TRIG)  act_q <= 1'b0;
    else if (start)              act_q <= 1'b1;
    else if (evt_o)              act_q <= 1'b0;
  end

  assign cnt_o = cnt_q;

  // R3
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && pend_q && !cnt_we_i |=> cnt_q == $past(load_i));
  // R4
  evt_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> cnt_q == $past(cmp_i));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == CM_TRIG && !act_q && !trig_i && !cnt_we_i |=> $stable(cnt_q));
  // R7
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == CM_TRIG && act_q && !evt_o |=> act_q);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              prim_i,
  input  logic              sec_i,
  output logic              oflag_o,
  output logic              irq_o
);
  localparam int N_IN = 2;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic [CNT_W-1:0] load_q, cmpa_q, cmpb_q, cnt, cmp_act, rdata_q;
  logic flag_q, oflag_q, run, evt;
  logic [N_IN-1:0] raw, lvl, dly, rise;
  logic pre_tick, pre_lvl, tick, prim_lvl;

  assign raw = {sec_i, prim_i};
  for (genvar g = 0; g < N_IN; g++) begin : g_in
    tmr_sync i_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw[g]),
      .sync_o(lvl[g]), .dly_o(dly[g])
    );
    assign rise[g] = lvl[g] && !dly[g];
  end

  tmr_prescale #(.PSC_W(PSC_W)) i_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .psc_i(ctrl_q.psc),
    .tick_o(pre_tick), .lvl_o(pre_lvl)
  );

  assign tick     = ctrl_q.src_ext ? rise[0] : pre_tick;
  assign prim_lvl = ctrl_q.src_ext ? lvl[0] : pre_lvl;
  assign cmp_act  = ctrl_q.cmp_sel ? cmpb_q : cmpa_q;

  tmr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(ctrl_q.cnt_mode),
    .tick_i(tick), .trig_i(rise[1]), .cmp_i(cmp_act), .load_i(load_q),
    .cnt_we_i(bus_we_i && bus_addr_i == A_CNT), .cnt_wdata_i(bus_wdata_i),
    .cnt_o(cnt), .run_o(run), .evt_o(evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else if (bus_we_i) begin
      case (bus_addr_i)
        A_CTRL:  ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
        A_LOAD:  load_q <= bus_wdata_i;
        A_CMPA:  cmpa_q <= bus_wdata_i;
        A_CMPB:  cmpb_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (bus_we_i && bus_addr_i == A_STAT && bus_wdata_i[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oflag_q <= 1'b0;
    else begin
      case (ctrl_q.out_mode)
        OM_TOGGLE: oflag_q <= oflag_q ^ evt;
        OM_GATE:   oflag_q <= prim_lvl && run;
        default:   oflag_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (bus_re_i) begin
      case (bus_addr_i)
        A_CTRL:  rdata_q <= CNT_W'(ctrl_q);
        A_STAT:  rdata_q <= CNT_W'({oflag_q, run, flag_q});
        A_CNT:   rdata_q <= cnt;
        A_LOAD:  rdata_q <= load_q;
        A_CMPA:  rdata_q <= cmpa_q;
        A_CMPB:  rdata_q <= cmpb_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign oflag_o     = oflag_q;
  assign irq_o       = flag_q && ctrl_q.irq_en;

  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag_q);
  // R9
  gate_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.out_mode == OM_GATE && !run |=> !oflag_o);
  // R8
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.out_mode == OM_TOGGLE && !evt |=> $stable(oflag_o));
endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, prim = 1'b0, sec = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic oflag, irq;

  tmr_chan i_tmr_chan (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .prim_i(prim), .sec_i(sec), .oflag_o(oflag), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0, rises = 0;
  logic rv = 1'b0, of_prev = 1'b0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against queued expectations
  always @(posedge clk) rv <= re;
  always @(negedge clk) begin : mon
    item_t it;
    if (rv && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(it.tag, rdata, it.exp);
    end
    if (oflag && !of_prev) rises++;
    of_prev = oflag;
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk); re = 1'b1; addr = a;
    sb_q.push_back(it);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic ppulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); prim = 1'b1;
      repeat (2) @(negedge clk); prim = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic spulse();
    @(negedge clk); sec = 1'b1;
    repeat (2) @(negedge clk); sec = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(int cm, int om, int psc, int ext, int sel, int ien);
    return 16'(cm | (om << 3) | (psc << 6) | (ext << 9) | (sel << 10) | (ien << 11));
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 16'h0, "R1 ctrl");
    rd(3'd2, 16'h0, "R1 cnt");
    rd(3'd1, 16'h0, "R1 stat");
    rd(3'd4, 16'h0, "R1 cmpa");
    @(negedge clk);
    check("R1 oflag", 16'(oflag), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);

    // R2 external edge counting, R4 flag
    wr(3'd3, 16'd10); wr(3'd4, 16'd3); wr(3'd2, 16'd0);
    wr(3'd0, ctl(1, 0, 0, 1, 0, 0));
    ppulse(2);
    rd(3'd2, 16'd2, "R2 two edges");
    ppulse(1);
    rd(3'd2, 16'd3, "R2 at compare");
    rd(3'd1, 16'h3, "R4 flag set");
    @(negedge clk);
    check("R4 irq masked", 16'(irq), 16'h0);
    wr(3'd0, ctl(1, 0, 0, 1, 0, 1));
    @(negedge clk);
    check("R4 irq enabled", 16'(irq), 16'h1);
    // R3 compare rewritten after match: still reload
    wr(3'd4, 16'd100);
    ppulse(1);
    rd(3'd2, 16'd10, "R3 reload after compare rewrite");
    ppulse(1);
    rd(3'd2, 16'd11, "R2 count after reload");
    // R4 write-one-to-clear
    wr(3'd1, 16'h0);
    rd(3'd1, 16'h3, "R4 write 0 keeps flag");
    wr(3'd1, 16'h1);
    rd(3'd1, 16'h2, "R4 write 1 clears flag");
    @(negedge clk);
    check("R4 irq cleared", 16'(irq), 16'h0);

    // R5 compare B
    wr(3'd5, 16'd13);
    wr(3'd0, ctl(1, 0, 0, 1, 1, 0));
    ppulse(2);
    rd(3'd1, 16'h3, "R5 event on compare B");
    ppulse(1);
    rd(3'd2, 16'd10, "R5 reload after compare B");

    // R8 toggle output
    wr(3'd1, 16'h1); wr(3'd3, 16'd0); wr(3'd4, 16'd2); wr(3'd2, 16'd0);
    wr(3'd0, ctl(1, 3, 0, 1, 0, 0));
    ppulse(2);
    @(negedge clk);
    check("R8 first toggle", 16'(oflag), 16'h1);
    ppulse(1);
    check("R8 no event holds", 16'(oflag), 16'h1);
    ppulse(2);
    check("R8 second toggle", 16'(oflag), 16'h0);

    // R10 prescaler 2^2 over 40 clocks
    wr(3'd0, 16'h0); wr(3'd4, 16'hFFFF); wr(3'd2, 16'd0);
    wr(3'd0, ctl(1, 0, 2, 0, 0, 0));
    repeat (38) @(negedge clk);
    wr(3'd0, 16'h0);
    rd(3'd2, 16'd10, "R10 divide by four");

    // R6/R9 triggered one-shot with gated output, external source
    wr(3'd1, 16'h1); wr(3'd3, 16'd0); wr(3'd4, 16'd4); wr(3'd2, 16'd0);
    wr(3'd0, ctl(6, 7, 0, 1, 0, 0));
    rises = 0;
    ppulse(3);
    rd(3'd2, 16'd0, "R6 idle before trigger");
    check("R9 silent before trigger", 16'(rises), 16'd0);
    spulse();
    rd(3'd1, 16'h2, "R6 running after trigger");
    ppulse(6);
    rd(3'd2, 16'd4, "R6 stop at compare");
    check("R9 pulse count", 16'(rises), 16'd4);
    rd(3'd1, 16'h1, "R6 stopped with flag");

    // R7 retrigger while running ignored
    wr(3'd1, 16'h1);
    spulse();
    ppulse(2);
    rd(3'd2, 16'd2, "R6 rearm from load");
    spulse();
    rd(3'd2, 16'd2, "R7 trigger while running");
    ppulse(2);
    rd(3'd2, 16'd4, "R7 run completes");

    // R9 internal source gated
    wr(3'd0, ctl(6, 7, 1, 0, 0, 0));
    rises = 0;
    repeat (60) @(negedge clk);
    check("R9 internal silent before trigger", 16'(rises), 16'd0);
    spulse();
    repeat (12) @(negedge clk);
    check("R9 internal pulse count", 16'(rises), 16'd4);
    rd(3'd2, 16'd4, "R10 internal one-shot count");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule